// File: doc/BRIEF.md
# Branch Condition and Delay-Slot Annul Resolver

This block resolves control transfers for a pipeline that has exactly one delay slot after every branch. A request carries the PC of the transfer instruction, a flag saying whether it is a call or a conditional branch, a 4-bit condition selector, the annul bit, a 30-bit offset field, and the integer N, Z, V and C flags that are current when the request is issued. The block answers with whether control is transferred, the target address, whether the delay-slot instruction must be cancelled, and a link-register write for calls.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one register stage. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its result is presented on the response port from that edge on. The response stays unchanged until it is consumed by `rsp_ready`. The block accepts a new request only when the response register is empty or is being drained in the same cycle, so at most one result is in flight.

Top module: `branch_resolve`

## Requirements
- R1: A request accepted on a rising edge (req_valid and req_ready high) has its result on the response port with rsp_valid high right after that same edge; req_ready is low only while rsp_valid is high and rsp_ready is low.
- R2: While rsp_valid is high and rsp_ready is low, every response output holds its value and no new request is accepted.
- R3: While reset (rst_n low) is applied and right after it, rsp_valid is 0 and req_ready is 1.
- R4: For a branch, selector codes 0 to 8 decide taken as follows: 0 never, 1 Z, 2 Z or (N xor V), 3 N xor V, 4 C or Z, 5 C, 6 N, 7 V, 8 always.
- R5: For a branch, selector codes 9 to 15 are the logical complements of codes 1 to 7 in that order (9 not-equal, 10 greater, 11 greater-or-equal, 12 greater-unsigned, 13 carry clear, 14 positive, 15 overflow clear).
- R6: A branch target is the PC plus bits 21:0 of the offset, sign-extended and multiplied by 4, modulo 2^32; offset bits 29:22 have no effect on a branch.
- R7: A branch with the annul bit at 0 never cancels the delay slot, whatever its outcome.
- R8: A branch with the annul bit at 1 cancels the delay slot when it is not taken and keeps it when taken, except that with selector 0 or 8 the slot is always cancelled.
- R9: A call is always taken, never cancels its delay slot regardless of annul and selector, and its target is the PC plus the 30-bit offset multiplied by 4, modulo 2^32.
- R10: A call asserts rsp_link_we with rsp_link_idx equal to 15 and rsp_link_data equal to the call's own PC; a branch gives rsp_link_we 0 and rsp_link_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_pc | input | 32 | PC of the transfer instruction |
| req_is_call | input | 1 | 1 for a call, 0 for a conditional branch |
| req_cond | input | 4 | Condition selector (branch only) |
| req_annul | input | 1 | Annul bit (branch only) |
| req_offset | input | 30 | Word offset; a branch uses bits 21:0 |
| req_flag_n | input | 1 | Negative flag |
| req_flag_z | input | 1 | Zero flag |
| req_flag_v | input | 1 | Overflow flag |
| req_flag_c | input | 1 | Carry flag |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_taken | output | 1 | Control is transferred |
| rsp_target | output | 32 | Transfer target address |
| rsp_cancel_slot | output | 1 | Delay-slot instruction must be cancelled |
| rsp_link_we | output | 1 | Write the return address to the link register |
| rsp_link_idx | output | 5 | Link register index |
| rsp_link_data | output | 32 | Return address to write |

## Verification
Every result is due one rising edge after its request is accepted: the single response register loads on the accepting edge, so the bench drives a request on a falling edge, lets one rising edge pass, and reads the response on the next falling edge. Under back-pressure the bench holds rsp_ready low for two more edges and re-reads the same response to confirm it did not move and that a waiting request was refused, then releases rsp_ready and expects the waiting request's result exactly one edge later. Because all sampling happens at falling edges, half a cycle away from any register update, no check depends on process ordering at the clock edge.

// File: rtl/br_pkg.sv
package br_pkg;

  // Base condition index (low three selector bits); bit 3 of the selector
  // inverts the base result.
  typedef enum logic [2:0] {
    BASE_FALSE = 3'd0,
    BASE_EQ    = 3'd1,
    BASE_LE    = 3'd2,
    BASE_LT    = 3'd3,
    BASE_LEU   = 3'd4,
    BASE_CS    = 3'd5,
    BASE_NEG   = 3'd6,
    BASE_VS    = 3'd7
  } br_base_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } br_flags_t;

  localparam int unsigned BR_NUM_BASE = 8;

  function automatic logic br_base_hit(input int unsigned idx, input br_flags_t f);
    logic r;
    case (br_base_e'(idx[2:0]))
      BASE_FALSE: r = 1'b0;
      BASE_EQ:    r = f.z;
      BASE_LE:    r = f.z | (f.n ^ f.v);
      BASE_LT:    r = f.n ^ f.v;
      BASE_LEU:   r = f.c | f.z;
      BASE_CS:    r = f.c;
      BASE_NEG:   r = f.n;
      BASE_VS:    r = f.v;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  br_flags_t        flags,
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic             unconditional
);
  localparam int unsigned BASE_W = SEL_W - 1;

  logic [BR_NUM_BASE-1:0] base_vec;

  // One evaluator per base condition; the selector picks one of them.
  for (genvar gi = 0; gi < BR_NUM_BASE; gi++) begin : g_base
    assign base_vec[gi] = br_base_hit(gi, flags);
  end

  logic [BASE_W-1:0] base_sel;
  logic              invert;

  assign base_sel      = sel[BASE_W-1:0];
  assign invert        = sel[SEL_W-1];
  assign hit           = base_vec[base_sel] ^ invert;
  assign unconditional = (base_sel == BASE_W'(BASE_FALSE));

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DISP_W   = 22,
  parameter bit          SHARE_ADD = 1'b1
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-3:0] offset,
  input  logic              is_call,
  output logic [ADDR_W-1:0] target
);
  localparam int unsigned OFF_W = ADDR_W - 2;
  localparam int unsigned EXT_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] br_step;
  logic [ADDR_W-1:0] call_step;

  assign br_step   = {{EXT_W{offset[DISP_W-1]}}, offset[DISP_W-1:0], 2'b00};
  assign call_step = {offset[OFF_W-1:0], 2'b00};

  if (SHARE_ADD) begin : g_shared
    // Select the step first, then a single adder.
    logic [ADDR_W-1:0] step;
    assign step   = is_call ? call_step : br_step;
    assign target = pc + step;
  end else begin : g_split
    // Two adders in parallel, select afterwards.
    logic [ADDR_W-1:0] br_sum;
    logic [ADDR_W-1:0] call_sum;
    assign br_sum   = pc + br_step;
    assign call_sum = pc + call_step;
    assign target   = is_call ? call_sum : br_sum;
  end

endmodule

// File: rtl/br_rsp_stage.sv
module br_rsp_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_ready) full_q <= in_valid;
      if (in_valid && in_ready) data_q <= in_data;
    end
  end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DISP_W    = 22,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned LINK_REG  = 15,
  parameter bit          SHARE_ADD = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_pc,
  input  logic                 req_is_call,
  input  logic [SEL_W-1:0]     req_cond,
  input  logic                 req_annul,
  input  logic [ADDR_W-3:0]    req_offset,
  input  logic                 req_flag_n,
  input  logic                 req_flag_z,
  input  logic                 req_flag_v,
  input  logic                 req_flag_c,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_taken,
  output logic [ADDR_W-1:0]    rsp_target,
  output logic                 rsp_cancel_slot,
  output logic                 rsp_link_we,
  output logic [REG_IDX_W-1:0] rsp_link_idx,
  output logic [ADDR_W-1:0]    rsp_link_data
);
  localparam int unsigned PAY_W = 3 + 2 * ADDR_W + REG_IDX_W;

  br_flags_t flags;
  assign flags = '{n: req_flag_n, z: req_flag_z, v: req_flag_v, c: req_flag_c};

  logic cond_hit;
  logic cond_uncond;

  br_cond_eval #(
    .SEL_W(SEL_W)
  ) u_cond (
    .flags        (flags),
    .sel          (req_cond),
    .hit          (cond_hit),
    .unconditional(cond_uncond)
  );

  logic [ADDR_W-1:0] nxt_target;

  br_target_gen #(
    .ADDR_W   (ADDR_W),
    .DISP_W   (DISP_W),
    .SHARE_ADD(SHARE_ADD)
  ) u_target (
    .pc     (req_pc),
    .offset (req_offset),
    .is_call(req_is_call),
    .target (nxt_target)
  );

  logic                 nxt_taken;
  logic                 nxt_cancel;
  logic                 nxt_link_we;
  logic [REG_IDX_W-1:0] nxt_link_idx;
  logic [ADDR_W-1:0]    nxt_link_data;

  always_comb begin
    nxt_taken     = req_is_call | cond_hit;
    // Annulled branch: slot survives only on a truly conditional taken branch.
    nxt_cancel    = !req_is_call && req_annul && (!cond_hit || cond_uncond);
    nxt_link_we   = req_is_call;
    nxt_link_idx  = REG_IDX_W'(LINK_REG);
    nxt_link_data = req_is_call ? req_pc : '0;
  end

  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign pay_in = {nxt_taken, nxt_target, nxt_cancel, nxt_link_we, nxt_link_idx, nxt_link_data};

  br_rsp_stage #(
    .DATA_W(PAY_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (pay_in),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (pay_out)
  );

  assign {rsp_taken, rsp_target, rsp_cancel_slot, rsp_link_we, rsp_link_idx, rsp_link_data} = pay_out;

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned LINK_REG  = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [ADDR_W-1:0]    req_pc,
  input logic                 req_is_call,
  input logic [SEL_W-1:0]     req_cond,
  input logic                 req_annul,
  input logic [ADDR_W-3:0]    req_offset,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic                 rsp_taken,
  input logic [ADDR_W-1:0]    rsp_target,
  input logic                 rsp_cancel_slot,
  input logic                 rsp_link_we,
  input logic [REG_IDX_W-1:0] rsp_link_idx,
  input logic [ADDR_W-1:0]    rsp_link_data
);
  // Shadow of the request whose result currently sits on the response port.
  logic              sh_call;
  logic [SEL_W-1:0]  sh_cond;
  logic              sh_annul;
  logic [ADDR_W-1:0] sh_pc;
  logic [ADDR_W-3:0] sh_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_call  <= 1'b0;
      sh_cond  <= '0;
      sh_annul <= 1'b0;
      sh_pc    <= '0;
      sh_off   <= '0;
    end else if (req_valid && req_ready) begin
      sh_call  <= req_is_call;
      sh_cond  <= req_cond;
      sh_annul <= req_annul;
      sh_pc    <= req_pc;
      sh_off   <= req_offset;
    end
  end

  assert_accept_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_taken) && $stable(rsp_target)
                                   && $stable(rsp_cancel_slot) && $stable(rsp_link_data)));

  assert_never_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !sh_call && sh_cond[SEL_W-2:0] == '0) |-> (rsp_taken == sh_cond[SEL_W-1]));

  assert_no_annul_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !sh_call && !sh_annul) |-> !rsp_cancel_slot);

  assert_annul_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !sh_call && sh_annul && !rsp_taken) |-> rsp_cancel_slot);

  assert_call_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && sh_call) |-> (rsp_taken && !rsp_cancel_slot
                                && rsp_target == sh_pc + {sh_off, 2'b00}));

  assert_link_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_link_we == sh_call
                   && (!sh_call || (rsp_link_idx == REG_IDX_W'(LINK_REG) && rsp_link_data == sh_pc))));

endmodule

bind branch_resolve branch_resolve_chk #(
  .ADDR_W   (ADDR_W),
  .SEL_W    (SEL_W),
  .REG_IDX_W(REG_IDX_W),
  .LINK_REG (LINK_REG)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_pc         (req_pc),
  .req_is_call    (req_is_call),
  .req_cond       (req_cond),
  .req_annul      (req_annul),
  .req_offset     (req_offset),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_taken      (rsp_taken),
  .rsp_target     (rsp_target),
  .rsp_cancel_slot(rsp_cancel_slot),
  .rsp_link_we    (rsp_link_we),
  .rsp_link_idx   (rsp_link_idx),
  .rsp_link_data  (rsp_link_data)
);

// File: tb/branch_resolve_test.sv
`timescale 1ns/1ps
module branch_resolve_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pc = '0;
  logic        req_is_call = 1'b0;
  logic [3:0]  req_cond = '0;
  logic        req_annul = 1'b0;
  logic [29:0] req_offset = '0;
  logic        req_flag_n = 1'b0;
  logic        req_flag_z = 1'b0;
  logic        req_flag_v = 1'b0;
  logic        req_flag_c = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_taken;
  logic [31:0] rsp_target;
  logic        rsp_cancel_slot;
  logic        rsp_link_we;
  logic [4:0]  rsp_link_idx;
  logic [31:0] rsp_link_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  branch_resolve uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_is_call(req_is_call), .req_cond(req_cond),
    .req_annul(req_annul), .req_offset(req_offset),
    .req_flag_n(req_flag_n), .req_flag_z(req_flag_z),
    .req_flag_v(req_flag_v), .req_flag_c(req_flag_c),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(rsp_taken), .rsp_target(rsp_target),
    .rsp_cancel_slot(rsp_cancel_slot), .rsp_link_we(rsp_link_we),
    .rsp_link_idx(rsp_link_idx), .rsp_link_data(rsp_link_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // Independent reference of the selector table (R4, R5).
  function automatic logic ref_taken(input logic [3:0] c, input logic n, input logic z,
                                     input logic v, input logic cy);
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return z | (n ^ v);
      4'd3:  return n ^ v;
      4'd4:  return cy | z;
      4'd5:  return cy;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1'b1;
      4'd9:  return !z;
      4'd10: return !(z | (n ^ v));
      4'd11: return !(n ^ v);
      4'd12: return !(cy | z);
      4'd13: return !cy;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  // Drive one request at a falling edge, let one rising edge accept it,
  // and return at the next falling edge where the result is due.
  task automatic issue(input logic call, input logic [31:0] pc, input logic [3:0] cond,
                       input logic annul, input logic [29:0] off, input logic [3:0] nzvc);
    @(negedge clk);
    req_valid   = 1'b1;
    req_is_call = call;
    req_pc      = pc;
    req_cond    = cond;
    req_annul   = annul;
    req_offset  = off;
    {req_flag_n, req_flag_z, req_flag_v, req_flag_c} = nzvc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic test_reset;
    check("R3 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R3 req_ready in reset", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R3 req_ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic test_conditions;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [3:0] nzvc;
        logic       exp_t;
        logic       an;
        nzvc  = 4'(f);
        an    = 1'(f + c);
        exp_t = ref_taken(4'(c), nzvc[3], nzvc[2], nzvc[1], nzvc[0]);
        issue(1'b0, 32'h0000_1000, 4'(c), an, 30'h0000_0010, nzvc);
        check("R1 rsp_valid one edge after accept", 32'(rsp_valid), 32'd1);
        if (c < 9) check("R4 taken", 32'(rsp_taken), 32'(exp_t));
        else       check("R5 taken", 32'(rsp_taken), 32'(exp_t));
        if (!an) check("R7 no cancel without annul", 32'(rsp_cancel_slot), 32'd0);
        else     check("R8 cancel with annul", 32'(rsp_cancel_slot),
                       32'(!exp_t || c == 0 || c == 8));
        check("R10 branch link_we", 32'(rsp_link_we), 32'd0);
        check("R10 branch link_data", rsp_link_data, 32'd0);
        @(negedge clk);
        check("R1 rsp drains", 32'(rsp_valid), 32'd0);
      end
    end
  endtask

  task automatic test_annul_cases;
    issue(1'b0, 32'h100, 4'd1, 1'b1, 30'h4, 4'b0100);
    check("R8 taken cond annul keeps slot", 32'(rsp_cancel_slot), 32'd0);
    issue(1'b0, 32'h100, 4'd1, 1'b1, 30'h4, 4'b0000);
    check("R8 untaken cond annul cancels", 32'(rsp_cancel_slot), 32'd1);
    issue(1'b0, 32'h100, 4'd8, 1'b1, 30'h4, 4'b0000);
    check("R8 always annul taken", 32'(rsp_taken), 32'd1);
    check("R8 always annul cancels", 32'(rsp_cancel_slot), 32'd1);
    issue(1'b0, 32'h100, 4'd0, 1'b1, 30'h4, 4'b1111);
    check("R8 never annul cancels", 32'(rsp_cancel_slot), 32'd1);
    issue(1'b0, 32'h100, 4'd0, 1'b0, 30'h4, 4'b1111);
    check("R7 never without annul keeps slot", 32'(rsp_cancel_slot), 32'd0);
  endtask

  task automatic test_branch_targets;
    issue(1'b0, 32'h0000_4000, 4'd8, 1'b0, 30'h001F_FFFF, 4'b0000);
    check("R6 max forward", rsp_target, 32'h0080_3FFC);
    issue(1'b0, 32'h0000_4000, 4'd8, 1'b0, 30'h0020_0000, 4'b0000);
    check("R6 max backward", rsp_target, 32'hFF80_4000);
    issue(1'b0, 32'h0000_4000, 4'd8, 1'b0, 30'h003F_FFFF, 4'b0000);
    check("R6 minus one word", rsp_target, 32'h0000_3FFC);
    issue(1'b0, 32'h0000_4000, 4'd8, 1'b0, {8'hA5, 22'h3F_FFFF}, 4'b0000);
    check("R6 upper offset bits ignored", rsp_target, 32'h0000_3FFC);
    issue(1'b0, 32'hFFFF_FFFC, 4'd8, 1'b0, 30'h0000_0001, 4'b0000);
    check("R6 wrap", rsp_target, 32'h0000_0000);
  endtask

  task automatic test_call;
    issue(1'b1, 32'hFFFF_FFF0, 4'd0, 1'b1, 30'h0000_0008, 4'b0000);
    check("R9 call taken", 32'(rsp_taken), 32'd1);
    check("R9 call no cancel", 32'(rsp_cancel_slot), 32'd0);
    check("R9 call wrap target", rsp_target, 32'h0000_0010);
    check("R10 call link_we", 32'(rsp_link_we), 32'd1);
    check("R10 call link_idx", 32'(rsp_link_idx), 32'd15);
    check("R10 call link_data", rsp_link_data, 32'hFFFF_FFF0);
    issue(1'b1, 32'h0000_1000, 4'd8, 1'b0, 30'h3FFF_FFFF, 4'b1010);
    check("R9 call backward", rsp_target, 32'h0000_0FFC);
    check("R10 call link_data 2", rsp_link_data, 32'h0000_1000);
    issue(1'b1, 32'h0000_0000, 4'd0, 1'b0, 30'h2000_0000, 4'b0000);
    check("R9 call high offset", rsp_target, 32'h8000_0000);
  endtask

  task automatic test_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    issue(1'b1, 32'h0000_2000, 4'd0, 1'b0, 30'h10, 4'b0000);
    check("R1 valid under stall", 32'(rsp_valid), 32'd1);
    check("R1 ready low under stall", 32'(req_ready), 32'd0);
    // Offer a second request while the first is stuck.
    req_valid   = 1'b1;
    req_is_call = 1'b0;
    req_pc      = 32'h0000_3000;
    req_cond    = 4'd8;
    req_annul   = 1'b0;
    req_offset  = 30'h0000_0002;
    @(negedge clk);
    @(negedge clk);
    check("R2 held target", rsp_target, 32'h0000_2040);
    check("R2 held link_we", 32'(rsp_link_we), 32'd1);
    check("R2 still valid", 32'(rsp_valid), 32'd1);
    check("R2 ready still low", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 second result after release", rsp_target, 32'h0000_3008);
    check("R1 second is branch", 32'(rsp_link_we), 32'd0);
    check("R1 second valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    check("R1 drained", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_conditions();
    test_annul_cases();
    test_branch_targets();
    test_call();
    test_backpressure();
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

endmodule